// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block divides one integer by another over several clock cycles. It serves both an unsigned divide and a signed divide instruction. A one-cycle start pulse delivers the dividend, the divisor, a mode bit and the index of the destination register. The block then runs one restoring step per clock on the operand magnitudes. When the quotient is ready, it raises a one-cycle done strobe. The strobe carries the quotient, the destination index, and a write request for the register file.

Some inputs would normally cause a fault. A zero divisor is one; in signed mode, the most negative value divided by minus one is another. The block never traps on these. It replaces the divisor with one, so the quotient equals the dividend. The quotient is `WIDTH` bits wide and is rounded toward zero. No remainder is returned. The only sign of activity given to the pipeline is a busy flag.

Top module: `int_divider`

## Requirements
- R1: With `signed_i` = 0 (unsigned mode), `quot_o` equals the unsigned floor of `dividend_i / divisor_i` for every non-zero divisor.
- R2: With `signed_i` = 1 (signed mode), both operands are two's complement. `quot_o` is the quotient truncated toward zero, reduced to `WIDTH` bits.
- R3: A divisor of zero, in either mode, is replaced by one, so `quot_o` equals `dividend_i`.
- R4: In signed mode, a dividend of the most negative value (only the top bit set) with a divisor of all ones (minus one) is also replaced by a divisor of one, so `quot_o` equals `dividend_i`.
- R5: `done_o` is high for exactly one cycle. That cycle follows the `WIDTH`-th rising edge after the edge that accepted the start.
- R6: `busy_o` is high from the cycle after an accepted start until `done_o` rises. It is low in the done cycle.
- R7: A start that arrives while `busy_o` is high is ignored. The result, the destination index and the latency of the running division are unchanged.
- R8: `dest_o` carries the destination index captured at the accepted start. `wr_en_o` is high only together with `done_o`, and only when that index is not zero.
- R9: After reset, `busy_o`, `done_o` and `wr_en_o` are low.
- R10: A start presented in the same cycle that `done_o` is high is accepted. A new division begins with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a division |
| signed_i | input | 1 | 1 = signed divide, 0 = unsigned divide |
| dividend_i | input | WIDTH | Dividend, sampled with the start |
| divisor_i | input | WIDTH | Divisor, sampled with the start |
| dest_i | input | IDX_W | Destination register index, sampled with the start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| wr_en_o | output | 1 | Register write request (done and index not zero) |
| dest_o | output | IDX_W | Destination index of the finished division |
| quot_o | output | WIDTH | Quotient |

## Verification
The completion of one division and the acceptance of the next one can fall in the same cycle. The bench provokes this on every operation of its sweep: it raises the next start on the very cycle it sees `done_o`. It then judges three things:
- whether `busy_o` comes back on the next cycle;
- whether that new operation still finishes with the correct quotient and destination;
- whether it still finishes after exactly `WIDTH` steps.

A separate run fires a stray start in the middle of a division. That run confirms the stray start leaves the running result, index and latency untouched.

// File: rtl/div_pkg.sv
// Package: shared mode encoding for the divider.
// Assumes: the mode bit from the decoder maps directly onto div_mode_e.
package div_pkg;
    typedef enum logic {
        DIV_UNSIGNED = 1'b0,
        DIV_SIGNED   = 1'b1
    } div_mode_e;
endpackage

// File: rtl/div_operand_prep.sv
// Module: div_operand_prep
// Turns raw operands into magnitudes plus a result-sign flag. It applies
// the substitution rule: the divisor becomes one when it is zero, or when
// a signed divide of the most negative value by minus one is requested.
// Assumes: purely combinational; the caller samples the outputs on start.
module div_operand_prep
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  div_mode_e        mode_i,
    output logic [WIDTH-1:0] a_mag_o,
    output logic [WIDTH-1:0] b_mag_o,
    output logic             neg_o
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MINUS_1  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    logic             is_signed;
    logic             swap_one;
    logic [WIDTH-1:0] b_eff;
    logic             a_neg;
    logic             b_neg;

    // Apply the substitution rule and split each operand into sign and magnitude.
    always_comb begin
        is_signed = (mode_i == DIV_SIGNED);
        swap_one  = (divisor_i == '0) ||
                    (is_signed && dividend_i == MOST_NEG && divisor_i == MINUS_1);
        b_eff     = swap_one ? ONE : divisor_i;
        a_neg     = is_signed && dividend_i[WIDTH-1];
        b_neg     = is_signed && b_eff[WIDTH-1];
        a_mag_o   = a_neg ? (~dividend_i + ONE) : dividend_i;
        b_mag_o   = b_neg ? (~b_eff + ONE) : b_eff;
        neg_o     = a_neg ^ b_neg;
    end
endmodule

// File: rtl/div_restoring_core.sv
// Module: div_restoring_core
// Radix-2 restoring divider on unsigned magnitudes. It produces one
// quotient bit per clock over WIDTH steps. fin_o marks the cycle whose
// step is the last one; q_next_o is then the complete magnitude quotient.
// Assumes: load_i only while busy_o is low; b_mag_i is never zero.
module div_restoring_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] a_mag_i,
    input  logic [WIDTH-1:0] b_mag_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [WIDTH-1:0] q_next_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] STEPS = CW'(WIDTH);
    localparam logic [CW-1:0] LAST  = CW'(1);

    logic [WIDTH-1:0] rem_q, quo_q, div_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH:0]   trial;
    logic             fits;
    logic [WIDTH-1:0] rem_next;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        trial    = {rem_q, quo_q[WIDTH-1]};
        fits     = (trial >= {1'b0, div_q});
        rem_next = fits ? ({rem_q[WIDTH-2:0], quo_q[WIDTH-1]} - div_q)
                        : {rem_q[WIDTH-2:0], quo_q[WIDTH-1]};
        q_next_o = {quo_q[WIDTH-2:0], fits};
        fin_o    = busy_o && (cnt_q == LAST);
    end

    // Iteration state: load on start, otherwise step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
        end else if (load_i) begin
            busy_o <= 1'b1;
            cnt_q  <= STEPS;
            rem_q  <= '0;
            quo_q  <= a_mag_i;
            div_q  <= b_mag_i;
        end else if (busy_o) begin
            rem_q  <= rem_next;
            quo_q  <= q_next_o;
            cnt_q  <= cnt_q - LAST;
            if (cnt_q == LAST) busy_o <= 1'b0;
        end
    end

    // The partial remainder always stays below the divisor during a run.
    assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rem_q < div_q));
    // The substitution rule guarantees the core never divides by zero.
    assert_divisor_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (div_q != '0));
endmodule

// File: rtl/div_result_stage.sv
// Module: div_result_stage
// Registers the finished quotient and restores its sign. It raises the
// done strobe and raises the write request only for a non-zero index.
// Assumes: fin_i is a single-cycle pulse from the core.
module div_result_stage #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_i,
    input  logic             neg_i,
    input  logic [WIDTH-1:0] q_mag_i,
    input  logic [IDX_W-1:0] dest_i,
    output logic             done_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] dest_o,
    output logic [WIDTH-1:0] quot_o
);
    // Capture the signed result and the strobes on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            wr_en_o <= 1'b0;
            dest_o  <= '0;
            quot_o  <= '0;
        end else begin
            done_o  <= fin_i;
            wr_en_o <= fin_i && (dest_i != '0);
            if (fin_i) begin
                dest_o <= dest_i;
                quot_o <= neg_i ? (~q_mag_i + 1'b1) : q_mag_i;
            end
        end
    end

    // Done never lasts two cycles.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/int_divider.sv
// Module: int_divider (top)
// A multi-cycle signed/unsigned integer divider. It accepts a start while
// idle and returns the quotient WIDTH+1 cycles later with a done strobe.
// Assumes: the issuing pipeline watches busy_o; starts while busy are dropped.
module int_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic [IDX_W-1:0] dest_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] dest_o,
    output logic [WIDTH-1:0] quot_o
);
    localparam int CW = $clog2(WIDTH + 1);

    logic             load;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic             neg_c, neg_q;
    logic [IDX_W-1:0] dest_q;
    logic             fin;
    logic [WIDTH-1:0] q_next;
    logic [CW-1:0]    lat_q;

    // Accept a start only when idle (a done cycle counts as idle).
    assign load = start_i && !busy_o;

    div_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .mode_i     (div_mode_e'(signed_i)),
        .a_mag_o    (a_mag),
        .b_mag_o    (b_mag),
        .neg_o      (neg_c)
    );

    div_restoring_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .a_mag_i  (a_mag),
        .b_mag_i  (b_mag),
        .busy_o   (busy_o),
        .fin_o    (fin),
        .q_next_o (q_next)
    );

    // Hold the result sign and destination for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            dest_q <= '0;
        end else if (load) begin
            neg_q  <= neg_c;
            dest_q <= dest_i;
        end
    end

    div_result_stage #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin_i   (fin),
        .neg_i   (neg_q),
        .q_mag_i (q_next),
        .dest_i  (dest_q),
        .done_o  (done_o),
        .wr_en_o (wr_en_o),
        .dest_o  (dest_o),
        .quot_o  (quot_o)
    );

    // Checker-only latency counter: busy cycles since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (load)   lat_q <= '0;
        else if (busy_o) lat_q <= lat_q + 1'b1;
    end

    assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == CW'(WIDTH)));
    assert_busy_clear_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(dest_q));
    assert_write_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (done_o && dest_o != '0));
endmodule

// File: tb/tb_int_divider.sv
// Bench: exhaustive sweep of a 6-bit divider in both modes, with
// back-to-back starts, a stray-start run and reset checks.
module tb_int_divider;
    localparam int W  = 6;
    localparam int IW = 5;
    localparam int M  = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [W-1:0]  dividend_i = '0;
    logic [W-1:0]  divisor_i = '0;
    logic [IW-1:0] dest_i = '0;
    logic          busy_o, done_o, wr_en_o;
    logic [IW-1:0] dest_o;
    logic [W-1:0]  quot_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    int_divider #(.WIDTH(W), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .dest_i(dest_i),
        .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o),
        .dest_o(dest_o), .quot_o(quot_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= M/2) ? v - M : v;
    endfunction

    function automatic int model(input int a, input int b, input bit sg);
        int q;
        if (b == 0) return a;                         // R3
        if (sg && a == M/2 && b == M-1) return a;     // R4
        if (sg) q = sx(a) / sx(b);                    // R2 truncation
        else    q = a / b;                            // R1
        return q & (M-1);
    endfunction

    // Called on a negedge: drive start, run to done, check everything.
    task automatic run_op(input int a, input int b, input bit sg, input int d,
                          input bit stray);
        int lat;
        int exp;
        string tag;
        exp = model(a, b, sg);
        tag = (b == 0) ? "R3" : (sg && a == M/2 && b == M-1) ? "R4" : sg ? "R2" : "R1";
        start_i = 1'b1; dividend_i = W'(a); divisor_i = W'(b);
        signed_i = sg; dest_i = IW'(d);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R6/R10 busy after start", int'(busy_o), 1);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (stray && lat == 2) begin
                start_i = 1'b1; dividend_i = W'(1); divisor_i = W'(1);
                dest_i = IW'(d ^ 5'h1F);
            end else if (stray && lat == 3) begin
                start_i = 1'b0;
            end
        end while (!done_o && lat < W + 6);
        check(int'(quot_o) == exp, tag, int'(quot_o), exp);
        check(lat == W && !busy_o, "R5/R6 latency", lat, W);
        check(int'(dest_o) == d && wr_en_o == (d != 0), "R8 dest/write",
              int'(dest_o) * 2 + int'(wr_en_o), d * 2 + int'(d != 0));
        if (stray) check(int'(quot_o) == exp && int'(dest_o) == d, "R7 stray start",
                         int'(quot_o), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !wr_en_o, "R9 reset", int'({busy_o, done_o, wr_en_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !wr_en_o, "R9 idle", int'({busy_o, done_o, wr_en_o}), 0);
        // R7: stray start mid-run
        run_op(50, 7, 1'b0, 9, 1'b1);
        @(negedge clk);
        check(!done_o && !busy_o, "R5 single pulse / R7 no extra run",
              int'({done_o, busy_o}), 0);
        // Exhaustive sweep, back-to-back (R10): each start on the done cycle.
        for (int sg = 0; sg < 2; sg++)
            for (int a = 0; a < M; a++)
                for (int b = 0; b < M; b++)
                    run_op(a, b, sg[0], (a ^ b) & 31, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule